// File: doc/BRIEF.md
# Sequential restoring divider

A multi-cycle integer divider that produces a quotient and a remainder from a dividend and a divisor of `W` bits each (32 by default). All working state lives in one shift register of double width plus one guard bit. The dividend magnitude is loaded into its low part and the high part starts at zero. The register shifts left once, and then runs `W` trial subtractions of the divisor against its high part. Each quotient bit enters at the low end as the register shifts. A final one-bit right shift of the high part gives the true remainder.

A caller pulses `start_i` while the block is idle, with the operands and a signed/unsigned select on the same cycle. Signed division works on magnitudes, and the signs are corrected on the way out. The quotient truncates toward zero and the remainder follows the sign of the dividend. A zero divisor bypasses the iteration and returns a fixed, flagged result on the next cycle.

Top module: `seq_divider`

## Requirements
- R1: With `signed_i`=0 and a nonzero divisor, `quotient_o` equals floor(dividend/divisor) and `remainder_o` equals dividend mod divisor, both operands read as unsigned.
- R2: With `signed_i`=1 and a nonzero divisor, operands are two's complement. The quotient is truncated toward zero and is negative when the operand signs differ. The remainder is zero or has the sign of the dividend. The most negative value divided by -1 gives the most negative value as quotient and 0 as remainder.
- R3: For every nonzero divisor, quotient×divisor + remainder equals the dividend modulo 2^W, and the remainder magnitude is strictly below the divisor magnitude.
- R4: A zero divisor, in either mode, sets `div_by_zero_o`=1, returns an all-ones quotient, returns the dividend bits unchanged as remainder, and raises `done_o` after the first rising edge that samples `start_i`. In this case `busy_o` stays 0.
- R5: For a nonzero divisor, `busy_o` is 1 after the edge that samples `start_i`. After the W+3-th edge following that one, `done_o` is 1 for exactly one cycle and `busy_o` returns to 0 on the same edge.
- R6: A `start_i` pulse while `busy_o`=1 is ignored: the result and its latency belong to the operation already running.
- R7: Operands and `signed_i` are sampled only on an accepted start. The result outputs hold their values after `done_o` until the next completion. `div_by_zero_o` is 0 for any nonzero-divisor result.
- R8: After reset, `busy_o`, `done_o`, `div_by_zero_o`, `quotient_o` and `remainder_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted when idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | W | Dividend |
| divisor_i | input | W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | W | Quotient |
| remainder_o | output | W | Remainder |
| div_by_zero_o | output | 1 | Last result came from a zero divisor |

## Verification
An upper half that was left unrestored after a failed trial, or a quotient bit that was shifted in wrong, corrupts every higher quotient bit. Because the result is only presented at completion, such a fault appears at `done_o` W+3 cycles after start, as a broken quotient×divisor+remainder identity or as an oversized remainder. A missing final right shift doubles the remainder, and a wrong step count moves the `done_o` pulse away from its expected cycle. Sweeping every operand pair in both modes on a 4-bit configuration exposes sign-correction errors, including the most-negative/-1 corner, directly in the output words.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_STEP  = 2'd2,
    ST_FIX   = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         signed_i,
  output logic [W-1:0] dvd_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output logic         neg_quo_o,
  output logic         neg_rem_o,
  output logic         dvs_zero_o
);
  logic dvd_neg;
  logic dvs_neg;

  always_comb begin
    dvd_neg    = signed_i & dividend_i[W-1];
    dvs_neg    = signed_i & divisor_i[W-1];
    dvd_mag_o  = dvd_neg ? (~dividend_i + 1'b1) : dividend_i;
    dvs_mag_o  = dvs_neg ? (~divisor_i + 1'b1) : divisor_i;
    neg_quo_o  = dvd_neg ^ dvs_neg;
    neg_rem_o  = dvd_neg;
    dvs_zero_o = (divisor_i == '0);
  end
endmodule

// File: rtl/div_trial_sub.sv
module div_trial_sub #(
  parameter int WA = 33
) (
  input  logic [WA-1:0] minuend_i,
  input  logic [WA-1:0] subtrahend_i,
  output logic [WA-1:0] diff_o,
  output logic          borrow_o
);
  logic [WA:0] full;

  always_comb begin
    full     = {1'b0, minuend_i} - {1'b0, subtrahend_i};
    diff_o   = full[WA-1:0];
    borrow_o = full[WA];
  end
endmodule

// File: rtl/div_iter_core.sv
module div_iter_core
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] dvd_mag_i,
  input  logic [W-1:0] dvs_mag_i,
  output logic         fin_o,
  output logic [W-1:0] quo_mag_o,
  output logic [W-1:0] rem_mag_o
);
  localparam int RW = 2 * W + 1;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  div_state_e     state;
  logic [RW-1:0]  acc;
  logic [W-1:0]   dvs_q;
  logic [CW-1:0]  cnt;
  logic           fin_q;

  logic [W:0]     hi;
  logic [W:0]     trial_diff;
  logic           trial_borrow;
  logic [W:0]     kept_hi;

  assign hi = acc[RW-1:W];

  div_trial_sub #(.WA(W + 1)) u_sub (
    .minuend_i    (hi),
    .subtrahend_i ({1'b0, dvs_q}),
    .diff_o       (trial_diff),
    .borrow_o     (trial_borrow)
  );

  // A failed trial restores the upper half by keeping its prior value
  assign kept_hi = trial_borrow ? hi : trial_diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      acc   <= '0;
      dvs_q <= '0;
      cnt   <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (load_i) begin
            acc   <= {{(W + 1){1'b0}}, dvd_mag_i};
            dvs_q <= dvs_mag_i;
            cnt   <= '0;
            state <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          acc   <= {acc[RW-2:0], 1'b0};
          state <= ST_STEP;
        end
        ST_STEP: begin
          acc <= {kept_hi[W-1:0], acc[W-1:0], ~trial_borrow};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX: begin
          acc[RW-1:W] <= {1'b0, acc[RW-1:W+1]};
          fin_q       <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fin_o     = fin_q;
  assign quo_mag_o = acc[W-1:0];
  assign rem_mag_o = acc[2*W-1:W];

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STEP) |-> (cnt < CW'(W)));

  assert_partial_rem_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STEP) |-> (hi[W:1] < dvs_q));

  assert_final_rem_R3: assert property (@(posedge clk) disable iff (rst)
    fin_q |-> (rem_mag_o < dvs_q));

  assert_load_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (state == ST_IDLE));
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag_i,
  input  logic [W-1:0] rem_mag_i,
  input  logic         neg_quo_i,
  input  logic         neg_rem_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  always_comb begin
    quo_o = neg_quo_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
    rem_o = neg_rem_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         div_by_zero_o
);
  logic [W-1:0] dvd_mag;
  logic [W-1:0] dvs_mag;
  logic         neg_quo;
  logic         neg_rem;
  logic         dvs_zero;
  logic         accept;
  logic         core_load;
  logic         core_fin;
  logic [W-1:0] core_quo;
  logic [W-1:0] core_rem;
  logic [W-1:0] fixed_quo;
  logic [W-1:0] fixed_rem;

  logic         busy_q;
  logic         done_q;
  logic         dbz_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] rem_q;
  logic         neg_quo_q;
  logic         neg_rem_q;

  assign accept    = start_i & ~busy_q;
  assign core_load = accept & ~dvs_zero;

  div_operand_prep #(.W(W)) u_prep (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .signed_i   (signed_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .neg_quo_o  (neg_quo),
    .neg_rem_o  (neg_rem),
    .dvs_zero_o (dvs_zero)
  );

  div_iter_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load_i    (core_load),
    .dvd_mag_i (dvd_mag),
    .dvs_mag_i (dvs_mag),
    .fin_o     (core_fin),
    .quo_mag_o (core_quo),
    .rem_mag_o (core_rem)
  );

  div_sign_fix #(.W(W)) u_fix (
    .quo_mag_i (core_quo),
    .rem_mag_i (core_rem),
    .neg_quo_i (neg_quo_q),
    .neg_rem_i (neg_rem_q),
    .quo_o     (fixed_quo),
    .rem_o     (fixed_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      dbz_q     <= 1'b0;
      quo_q     <= '0;
      rem_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (dvs_zero) begin
          quo_q  <= '1;
          rem_q  <= dividend_i;
          dbz_q  <= 1'b1;
          done_q <= 1'b1;
        end else begin
          busy_q    <= 1'b1;
          neg_quo_q <= neg_quo;
          neg_rem_q <= neg_rem;
        end
      end
      if (core_fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        dbz_q  <= 1'b0;
        quo_q  <= fixed_quo;
        rem_q  <= fixed_rem;
      end
    end
  end

  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign quotient_o    = quo_q;
  assign remainder_o   = rem_q;
  assign div_by_zero_o = dbz_q;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (divisor_i != '0)) |=> busy_o);

  assert_zero_result_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && div_by_zero_o) |-> (quotient_o == '1));

  assert_zero_no_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (divisor_i == '0)) |=> (!busy_o && done_o));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !core_fin) |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

// File: tb/seq_divider_test.sv
module seq_divider_test;
  localparam int W    = 4;
  localparam int LAT  = W + 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o;
  logic         done_o;
  logic [W-1:0] quotient_o;
  logic [W-1:0] remainder_o;
  logic         div_by_zero_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  seq_divider #(.W(W)) uut (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .signed_i      (signed_i),
    .dividend_i    (dividend_i),
    .divisor_i     (divisor_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .quotient_o    (quotient_o),
    .remainder_o   (remainder_o),
    .div_by_zero_o (div_by_zero_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sx(input logic [W-1:0] v, input bit sm);
    if (sm) return int'($signed(v));
    return int'(v);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit sm, input bit disturb);
    int ia, ib, eq, er, elat, cyc, iq, ir, prod;
    bit seen;
    logic [W-1:0] hq, hr;
    ia = sx(a, sm);
    ib = sx(b, sm);
    if (b == '0) begin
      eq = MASK; er = int'(a); elat = 1;
    end else begin
      eq = (ia / ib) & MASK; er = (ia % ib) & MASK; elat = LAT;
    end
    @(negedge clk);
    start_i = 1'b1; dividend_i = a; divisor_i = b; signed_i = sm;
    cyc = 0; seen = 0;
    while (!seen && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        start_i = 1'b0;
        // R5 / R4: busy only for a nonzero divisor
        check(busy_o == (b != '0), (b == '0) ? "R4" : "R5", "busy after start",
              int'(busy_o), int'(b != '0));
      end
      if (disturb && cyc == 2) begin
        start_i = 1'b1; dividend_i = ~a; divisor_i = b + 1'b1; signed_i = ~sm;
      end
      if (disturb && cyc == 3) start_i = 1'b0;
      if (done_o) seen = 1;
    end
    check(cyc == elat, disturb ? "R6" : "R5", "done latency", cyc, elat);
    check(!busy_o, "R5", "busy at done", int'(busy_o), 0);
    if (b == '0) begin
      check(div_by_zero_o == 1'b1, "R4", "flag", int'(div_by_zero_o), 1);
      check(int'(quotient_o) == eq, "R4", "quotient", int'(quotient_o), eq);
      check(int'(remainder_o) == er, "R4", "remainder", int'(remainder_o), er);
    end else begin
      check(div_by_zero_o == 1'b0, "R7", "flag clear", int'(div_by_zero_o), 0);
      check(int'(quotient_o) == eq, sm ? "R2" : "R1", "quotient", int'(quotient_o), eq);
      check(int'(remainder_o) == er, sm ? "R2" : "R1", "remainder", int'(remainder_o), er);
      iq = sx(quotient_o, sm);
      ir = sx(remainder_o, sm);
      prod = (iq * ib + ir) & MASK;
      check(prod == int'(a), "R3", "identity", prod, int'(a));
      check(iabs(ir) < iabs(ib), "R3", "remainder magnitude", iabs(ir), iabs(ib));
      if (sm) check(ir == 0 || ((ir < 0) == (ia < 0)), "R2", "remainder sign", ir, ia);
    end
    hq = quotient_o; hr = remainder_o;
    dividend_i = ~a; divisor_i = ~b; signed_i = ~sm;
    @(negedge clk);
    check(!done_o, "R5", "done single pulse", int'(done_o), 0);
    @(negedge clk);
    check(quotient_o == hq && remainder_o == hr, "R7", "hold quotient",
          int'(quotient_o), int'(hq));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(!busy_o, "R8", "busy", int'(busy_o), 0);
    check(!done_o, "R8", "done", int'(done_o), 0);
    check(!div_by_zero_o, "R8", "flag", int'(div_by_zero_o), 0);
    check(quotient_o == '0, "R8", "quotient", int'(quotient_o), 0);
    check(remainder_o == '0, "R8", "remainder", int'(remainder_o), 0);
    // corners first: most negative / -1, divide by zero in both modes
    run_op(4'b1000, 4'b1111, 1'b1, 1'b0);
    run_op(4'b1111, 4'b0000, 1'b0, 1'b0);
    run_op(4'b1001, 4'b0000, 1'b1, 1'b0);
    run_op(4'b1111, 4'b1111, 1'b0, 1'b1);
    // exhaustive sweep, both modes
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x <= MASK; x++) begin
        for (int y = 0; y <= MASK; y++) begin
          run_op(W'(x), W'(y), m[0], bit'(((x ^ y) >> 1) & 1));
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule